// File: doc/BRIEF.md
# Blocking/Non-blocking Message Channel Unit

This block sits between a processing core and the I/O facilities around it and carries 32-bit messages through a set of numbered, one-way channels. Channels are addressed by a 7-bit number, so up to 128 can exist. Each channel is a small FIFO of `DEPTH` entries (1 to 4). A channel is one of two types. An inbound channel is filled by a facility and drained by the core. An outbound channel is filled by the core and drained by a facility. Both the type and the behaviour when a channel is unavailable are fixed per channel by parameter masks.

The core issues one operation at a time on a valid/ready request port. The operations are read, write and count. A request transfers when `req_valid` and `req_ready` are both high at a clock edge. Its response appears on `rsp_*` for exactly one cycle, one cycle after the transfer, and the response path has no back-pressure. A blocking channel that is empty on read, or full on write, holds `req_ready` low, so `core_stall` stays high until the facility side makes room or data. A non-blocking channel answers at once with a failure flag. The facility side has two valid/ready streams, one for pushing inbound data and one for pulling outbound data. Each stream selects its channel with its own channel number.

Top module: `chan_msg_unit`

## Requirements
- R1: After reset, no response is valid, `core_stall` is low, every channel is empty (`out_valid` low for every outbound channel), and `req_ready` is high for count operations.
- R2: The count operation (`req_op` = 2'b10) returns, zero-extended, the number of entries held for an inbound channel or the number of free slots for an outbound channel. The value is taken before any change in the same cycle.
- R3: Each channel delivers its data in the order written: core reads (`req_op` = 2'b00) return inbound data in push order, and `out_data` presents outbound data in core-write (`req_op` = 2'b01) order.
- R4: A read of an empty blocking inbound channel keeps `req_ready` low and `core_stall` high, with no response, until data arrives. The read then completes with that data.
- R5: A write to a full blocking outbound channel keeps `core_stall` high until the facility drains an entry. The write then completes and its data is queued behind the remaining entries.
- R6: A read of an empty non-blocking inbound channel transfers at once and responds with `rsp_nb_fail` = 1 and `rsp_data` = 0. The channel stays empty.
- R7: A write to a full non-blocking outbound channel transfers at once with `rsp_nb_fail` = 1. The written word is discarded and the stored entries are unchanged.
- R8: A channel number at or above `NUM_CH`, a read of an outbound channel, a write of an inbound channel, or the reserved opcode 2'b11 transfers at once and responds with `rsp_illegal` = 1 and `rsp_data` = 0. No channel state changes.
- R9: `in_ready` is low only when `in_chan` names a full inbound channel. A push to any other channel number is accepted and dropped. `out_valid` is high only when `out_chan` names a non-empty outbound channel.
- R10: Every channel holds exactly `DEPTH` entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Request accepted this cycle |
| req_op | input | 2 | 00 read, 01 write, 10 count, 11 reserved |
| req_chan | input | 7 | Channel number |
| req_wdata | input | DATA_W | Write data |
| core_stall | output | 1 | Request pending but held back |
| rsp_valid | output | 1 | Response valid (one cycle) |
| rsp_data | output | DATA_W | Read data or count |
| rsp_nb_fail | output | 1 | Non-blocking access found channel unavailable |
| rsp_illegal | output | 1 | Bad channel, direction or opcode |
| in_valid | input | 1 | Facility push valid |
| in_ready | output | 1 | Push accepted |
| in_chan | input | 7 | Push channel number |
| in_data | input | DATA_W | Push data |
| out_chan | input | 7 | Channel the facility drains |
| out_valid | output | 1 | Selected outbound channel has data |
| out_ready | input | 1 | Facility takes the word |
| out_data | output | DATA_W | Head of selected outbound channel |

## Verification
The bench goes after the points where a channel is unavailable.

- **Blocking reads and writes.** The bench holds a blocking read and a blocking write pending and only later unblocks them from the facility side. A design that ignored the mode would answer early with stale data. One that forgot to re-evaluate would hang.
- **Non-blocking overflow.** The bench overfills a non-blocking channel, then drains it and compares the order. A design that wrote the rejected word would show an extra or overwritten entry.
- **Illegal accesses.** Out-of-range numbers and wrong-direction accesses are followed by count reads, to prove that nothing moved.
- **Capacity.** A pointer wrap at a non-power-of-two depth exposes an off-by-one, which would reorder or lose words.

// File: rtl/chan_pkg.sv
package chan_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_COUNT = 2'b10,
    OP_RSVD  = 2'b11
  } chan_op_e;

  typedef struct packed {
    logic grant;      // request may transfer this cycle
    logic core_push;  // core write lands in the channel
    logic core_pop;   // core read removes the head
    logic fail;       // non-blocking access on unavailable channel
    logic illegal;    // bad channel, direction or opcode
    logic ret_head;   // respond with head data
    logic ret_cnt;    // respond with availability
  } access_t;

endpackage

// File: rtl/chan_fifo.sv
module chan_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 3,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic [CW-1:0]     count
);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PW-1:0]     rd_ptr, wr_ptr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= push_data;
  end

  assign head = store[rd_ptr];

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> (count < CW'(DEPTH)));

  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));

endmodule

// File: rtl/chan_access_ctl.sv
module chan_access_ctl
  import chan_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DEPTH  = 3,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          req_valid,
  input  chan_op_e      op,
  input  logic [6:0]    chan,
  input  logic [CW-1:0] cnt_sel,
  input  logic          is_out_ch,
  input  logic          is_blk,
  output access_t       acc,
  output logic [CW-1:0] avail
);

  logic legal_ch;
  logic has_data, has_room;

  assign legal_ch = ({1'b0, chan} < 8'(NUM_CH));
  assign has_data = (cnt_sel != '0);
  assign has_room = (cnt_sel < CW'(DEPTH));
  assign avail    = is_out_ch ? (CW'(DEPTH) - cnt_sel) : cnt_sel;

  always_comb begin
    acc = '0;
    unique case (op)
      OP_READ: begin
        if (!legal_ch || is_out_ch) begin
          acc.grant = 1'b1; acc.illegal = 1'b1;
        end else if (has_data) begin
          acc.grant = 1'b1; acc.core_pop = req_valid; acc.ret_head = 1'b1;
        end else if (!is_blk) begin
          acc.grant = 1'b1; acc.fail = 1'b1;
        end
      end
      OP_WRITE: begin
        if (!legal_ch || !is_out_ch) begin
          acc.grant = 1'b1; acc.illegal = 1'b1;
        end else if (has_room) begin
          acc.grant = 1'b1; acc.core_push = req_valid;
        end else if (!is_blk) begin
          acc.grant = 1'b1; acc.fail = 1'b1;
        end
      end
      OP_COUNT: begin
        acc.grant = 1'b1;
        if (legal_ch) acc.ret_cnt = 1'b1;
        else          acc.illegal = 1'b1;
      end
      default: begin
        acc.grant = 1'b1; acc.illegal = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/chan_msg_unit.sv
module chan_msg_unit
  import chan_pkg::*;
#(
  parameter int                NUM_CH   = 8,
  parameter int                DEPTH    = 3,
  parameter int                DATA_W   = 32,
  parameter logic [NUM_CH-1:0] OUT_MASK = 8'hF0,
  parameter logic [NUM_CH-1:0] BLK_MASK = 8'h33,
  localparam int               IDX_W    = $clog2(NUM_CH),
  localparam int               CW       = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [6:0]        req_chan,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              core_stall,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_nb_fail,
  output logic              rsp_illegal,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [6:0]        in_chan,
  input  logic [DATA_W-1:0] in_data,
  input  logic [6:0]        out_chan,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);

  logic [CW-1:0]     cnt  [NUM_CH];
  logic [DATA_W-1:0] head [NUM_CH];

  logic [IDX_W-1:0] req_idx, in_idx, out_idx;
  logic             req_legal, in_legal, out_legal;
  logic [CW-1:0]    cnt_sel, avail;
  logic             sel_out, sel_blk;
  access_t          acc;

  assign req_idx   = req_chan[IDX_W-1:0];
  assign in_idx    = in_chan[IDX_W-1:0];
  assign out_idx   = out_chan[IDX_W-1:0];
  assign req_legal = ({1'b0, req_chan} < 8'(NUM_CH));
  assign in_legal  = ({1'b0, in_chan}  < 8'(NUM_CH));
  assign out_legal = ({1'b0, out_chan} < 8'(NUM_CH));

  assign cnt_sel = req_legal ? cnt[req_idx] : '0;
  assign sel_out = req_legal & OUT_MASK[req_idx];
  assign sel_blk = req_legal & BLK_MASK[req_idx];

  chan_access_ctl #(.NUM_CH(NUM_CH), .DEPTH(DEPTH)) u_ctl (
    .req_valid (req_valid),
    .op        (chan_op_e'(req_op)),
    .chan      (req_chan),
    .cnt_sel   (cnt_sel),
    .is_out_ch (sel_out),
    .is_blk    (sel_blk),
    .acc       (acc),
    .avail     (avail)
  );

  assign req_ready  = acc.grant;
  assign core_stall = req_valid & ~acc.grant;

  // Facility-side handshakes
  assign in_ready  = (in_legal && !OUT_MASK[in_idx]) ? (cnt[in_idx] < CW'(DEPTH)) : 1'b1;
  assign out_valid = out_legal && OUT_MASK[out_idx] && (cnt[out_idx] != '0);
  assign out_data  = out_legal ? head[out_idx] : '0;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic              push, pop;
    logic [DATA_W-1:0] pdata;
    if (OUT_MASK[i]) begin : g_out
      assign push  = acc.core_push && req_legal && (req_idx == IDX_W'(i));
      assign pdata = req_wdata;
      assign pop   = out_valid && out_ready && (out_idx == IDX_W'(i));
    end else begin : g_in
      assign push  = in_valid && in_ready && in_legal && (in_idx == IDX_W'(i));
      assign pdata = in_data;
      assign pop   = acc.core_pop && req_legal && (req_idx == IDX_W'(i));
    end
    chan_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_data (pdata),
      .pop       (pop),
      .head      (head[i]),
      .count     (cnt[i])
    );
  end

  // Response register: one cycle after transfer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_data    <= '0;
      rsp_nb_fail <= 1'b0;
      rsp_illegal <= 1'b0;
    end else begin
      rsp_valid   <= req_valid & acc.grant;
      rsp_nb_fail <= acc.fail;
      rsp_illegal <= acc.illegal;
      if (acc.ret_head)     rsp_data <= head[req_idx];
      else if (acc.ret_cnt) rsp_data <= DATA_W'(avail);
      else                  rsp_data <= '0;
    end
  end

  assert_stall_no_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    core_stall |=> !rsp_valid);

  assert_illegal_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_illegal) |-> (rsp_data == '0 && !rsp_nb_fail));

  assert_fail_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_nb_fail) |-> (rsp_data == '0));

  assert_out_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !req_valid && $stable(out_chan)) |=> $stable(out_data));

endmodule

// File: tb/chan_msg_unit_bench.sv
`timescale 1ns/1ps
module chan_msg_unit_bench;

  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = 2'b00;
  logic [6:0]    req_chan = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          core_stall;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          rsp_nb_fail, rsp_illegal;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [6:0]    in_chan = '0;
  logic [DW-1:0] in_data = '0;
  logic [6:0]    out_chan = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [DW-1:0] out_data;

  always #2 clk = ~clk;

  chan_msg_unit u_chan_msg_unit (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_chan(req_chan), .req_wdata(req_wdata), .core_stall(core_stall),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_nb_fail(rsp_nb_fail),
    .rsp_illegal(rsp_illegal),
    .in_valid(in_valid), .in_ready(in_ready), .in_chan(in_chan), .in_data(in_data),
    .out_chan(out_chan), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [DW-1:0] d;
    bit            f;
    bit            il;
    string         tag;
  } exp_t;
  exp_t sb[$];

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Driver: queue the expected response, then hold the request until it transfers
  task automatic core_op(input logic [1:0] op, input logic [6:0] ch, input logic [DW-1:0] wd,
                         input logic [DW-1:0] ed, input bit ef, input bit eil, input string tag);
    exp_t e;
    e.d = ed; e.f = ef; e.il = eil; e.tag = tag;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_chan = ch; req_wdata = wd;
    sb.push_back(e);
    while (1) begin
      #1;
      if (req_ready) begin
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
    #1 req_valid = 1'b0;
  endtask

  task automatic io_push(input logic [6:0] ch, input logic [DW-1:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_chan = ch; in_data = d;
    while (1) begin
      #1;
      if (in_ready) begin
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
    #1 in_valid = 1'b0;
  endtask

  task automatic io_pop(input logic [6:0] ch, input logic [DW-1:0] ed, input string tag);
    @(negedge clk);
    out_ready = 1'b1; out_chan = ch;
    while (1) begin
      #1;
      if (out_valid) begin
        chk(out_data == ed, tag, out_data, ed);
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
    #1 out_ready = 1'b0;
  endtask

  // Monitor: compare each response with the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        chk(1'b0, "unexpected response", rsp_data, '0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(rsp_data == e.d && rsp_nb_fail == e.f && rsp_illegal == e.il, e.tag,
            {rsp_data[DW-3:0], rsp_nb_fail, rsp_illegal}, {e.d[DW-3:0], e.f, e.il});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", '0, '0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1: reset state
    chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", DW'(rsp_valid), 0);
    chk(core_stall == 1'b0, "R1 stall after reset", DW'(core_stall), 0);
    out_chan = 7'd4; #0.1;
    chk(out_valid == 1'b0, "R1 outbound empty after reset", DW'(out_valid), 0);
    core_op(2'b10, 7'd0, '0, 0, 0, 0, "R1 R2 inbound count after reset");
    core_op(2'b10, 7'd4, '0, 3, 0, 0, "R1 R2 outbound free after reset");

    // R3/R10: fill inbound channel 0, full blocks further pushes
    io_push(7'd0, 32'h11);
    io_push(7'd0, 32'h22);
    io_push(7'd0, 32'h33);
    @(negedge clk); in_chan = 7'd0; #1;
    chk(in_ready == 1'b0, "R9 R10 in_ready low when full", DW'(in_ready), 0);
    core_op(2'b10, 7'd0, '0, 3, 0, 0, "R2 R10 inbound count full");
    core_op(2'b00, 7'd0, '0, 32'h11, 0, 0, "R3 order 1");
    core_op(2'b00, 7'd0, '0, 32'h22, 0, 0, "R3 order 2");
    io_push(7'd0, 32'h44);
    core_op(2'b00, 7'd0, '0, 32'h33, 0, 0, "R3 order 3");
    core_op(2'b00, 7'd0, '0, 32'h44, 0, 0, "R3 order wrap");
    core_op(2'b10, 7'd0, '0, 0, 0, 0, "R2 count after drain");

    // R6: non-blocking read on empty channel
    core_op(2'b00, 7'd2, '0, 0, 1, 0, "R6 nb read empty");
    core_op(2'b10, 7'd2, '0, 0, 0, 0, "R6 channel still empty");
    io_push(7'd2, 32'h55);
    core_op(2'b00, 7'd2, '0, 32'h55, 0, 0, "R6 nb read with data");

    // R4: blocking read stalls until data arrives
    fork
      core_op(2'b00, 7'd1, '0, 32'h77, 0, 0, "R4 blocking read data");
      begin
        repeat (3) @(negedge clk);
        #1;
        chk(core_stall == 1'b1, "R4 stall held", DW'(core_stall), 1);
        chk(rsp_valid == 1'b0, "R4 no response while stalled", DW'(rsp_valid), 0);
        io_push(7'd1, 32'h77);
      end
    join

    // R5: blocking write stalls until the facility drains
    core_op(2'b01, 7'd4, 32'hA1, 0, 0, 0, "R5 write 1");
    core_op(2'b01, 7'd4, 32'hA2, 0, 0, 0, "R5 write 2");
    core_op(2'b01, 7'd4, 32'hA3, 0, 0, 0, "R5 write 3");
    core_op(2'b10, 7'd4, '0, 0, 0, 0, "R2 R10 outbound free when full");
    fork
      core_op(2'b01, 7'd4, 32'hB4, 0, 0, 0, "R5 blocked write completes");
      begin
        repeat (3) @(negedge clk);
        #1;
        chk(core_stall == 1'b1, "R5 stall held", DW'(core_stall), 1);
        io_pop(7'd4, 32'hA1, "R3 R5 drain 1");
      end
    join
    io_pop(7'd4, 32'hA2, "R3 R5 drain 2");
    io_pop(7'd4, 32'hA3, "R3 R5 drain 3");
    io_pop(7'd4, 32'hB4, "R3 R5 drain queued word");
    @(negedge clk); out_chan = 7'd4; #1;
    chk(out_valid == 1'b0, "R9 out_valid low when empty", DW'(out_valid), 0);

    // R7: non-blocking write on full channel
    core_op(2'b01, 7'd6, 32'hC1, 0, 0, 0, "R7 fill 1");
    core_op(2'b01, 7'd6, 32'hC2, 0, 0, 0, "R7 fill 2");
    core_op(2'b01, 7'd6, 32'hC3, 0, 0, 0, "R7 fill 3");
    core_op(2'b01, 7'd6, 32'hC4, 0, 1, 0, "R7 nb write full fails");
    core_op(2'b10, 7'd6, '0, 0, 0, 0, "R7 still full");
    io_pop(7'd6, 32'hC1, "R7 contents 1");
    io_pop(7'd6, 32'hC2, "R7 contents 2");
    io_pop(7'd6, 32'hC3, "R7 contents 3");
    @(negedge clk); out_chan = 7'd6; #1;
    chk(out_valid == 1'b0, "R7 rejected word absent", DW'(out_valid), 0);

    // R8: illegal accesses
    core_op(2'b00, 7'd9, '0, 0, 0, 1, "R8 read out of range");
    core_op(2'b10, 7'd100, '0, 0, 0, 1, "R8 count out of range");
    core_op(2'b00, 7'd4, '0, 0, 0, 1, "R8 read of outbound");
    core_op(2'b01, 7'd0, 32'hEE, 0, 0, 1, "R8 write of inbound");
    core_op(2'b11, 7'd0, '0, 0, 0, 1, "R8 reserved opcode");
    core_op(2'b10, 7'd0, '0, 0, 0, 0, "R8 inbound unchanged");

    // R9: misdirected push is accepted and dropped
    @(negedge clk); in_chan = 7'd5; #1;
    chk(in_ready == 1'b1, "R9 ready on outbound channel number", DW'(in_ready), 1);
    io_push(7'd5, 32'hDD);
    io_push(7'd9, 32'hDE);
    core_op(2'b10, 7'd5, '0, 3, 0, 0, "R9 outbound untouched by push");

    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "scoreboard drained", DW'(sb.size()), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule